// File: doc/BRIEF.md
# Register-Pair Transfer and Stack Unit

This block holds the byte registers of a small 8-bit processor core: an accumulator and six general registers grouped as three 16-bit pairs (BC, DE, HL). It also holds a 16-bit stack pointer (SP) and a 16-bit program counter (PC). It executes already-decoded 16-bit transfer commands. Some of them change only internal registers and finish in the cycle they are accepted. The rest are broken into a sequence of single-byte memory accesses. Within a 16-bit word, the low byte always sits at the lower address.

A command is presented on `cmd_valid` together with an opcode, a two-bit pair selector and a 16-bit operand. It is taken on any clock edge where the unit is not busy. Memory-bound commands raise `busy` and drive a byte request (`mem_req`, `mem_we`, `mem_addr`, `mem_wdata`). The request stays unchanged until the memory answers with `mem_ready`, and read data is sampled on that same edge. Every architectural register is visible on an output so the surrounding core can use it.

Top module: `pair_xfer_unit`

## Requirements
- R1: Opcode 0 loads the 16-bit operand into the pair chosen by the pair field (0 = BC, 1 = DE, 2 = HL, 3 = SP). The operand's upper byte goes to B, D or H and its lower byte to C, E or L. The change is visible after the accepting edge.
- R2: Opcode 1 performs two reads. The first reads the operand address into L and the second reads operand+1 into H.
- R3: Opcode 2 performs two writes. The first writes L to the operand address and the second writes H to operand+1.
- R4: Opcode 3 exchanges HL with DE on the accepting edge, and `busy` never rises for it.
- R5: Opcode 4 sets SP to HL, and opcode 5 sets PC to HL. Both complete on the accepting edge.
- R6: Opcode 6 exchanges HL with the word at the top of the stack. The access sequence is: read SP, write L to SP, read SP+1, write H to SP+1. Afterwards L and H hold the old memory bytes, and SP is unchanged.
- R7: Opcode 7 pushes a word. It decrements SP before each write, and writes the high byte first, then the low byte. The pair field selects the word (0 = BC, 1 = DE, 2 = HL, 3 = the accumulator as high byte with 0x00 as low byte). SP wraps modulo 2^16.
- R8: Opcode 8 pops a word into the selected pair, and opcode 9 pops a word into PC. Both read the low byte at SP and then the high byte at SP+1, and leave SP increased by 2. For opcode 8 with pair field 3, only the high byte is kept, and it goes to the accumulator.
- R9: Opcode 10 loads the accumulator from the address held in BC (pair bit 0 = 0) or DE (pair bit 0 = 1). Opcode 11 stores the accumulator to that address. The address pair is left unchanged.
- R10: `busy` is high from the cycle after a memory-bound command is accepted until its last access completes. A command offered while `busy` is high is ignored.
- R11: `mem_req` is held with a stable address, direction and write data until `mem_ready` is seen, and exactly the listed accesses occur.
- R12: Opcodes 12 to 15 have no effect: no memory request, no `busy`, and no register change.
- R13: A synchronous active-high reset clears the accumulator, all pairs, SP, PC and `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is offered |
| cmd_op | input | 4 | Decoded opcode |
| cmd_pair | input | 2 | Pair selector |
| cmd_imm | input | 16 | 16-bit operand |
| busy | output | 1 | A multi-access command is in progress |
| mem_req | output | 1 | Byte access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, taken when `mem_ready` is high |
| mem_ready | input | 1 | Memory completes the current access |
| acc_o | output | 8 | Accumulator |
| bc_o | output | 16 | Pair BC |
| de_o | output | 16 | Pair DE |
| hl_o | output | 16 | Pair HL |
| sp_o | output | 16 | Stack pointer |
| pc_o | output | 16 | Program counter |

## Verification
The bench builds the unit with its default byte width of 8, so addresses are 16 bits wide. Starting SP at zero then brings the stack-pointer wrap to 0xFFFF within a couple of pushes. The bench's memory model is run with 0, 2 and 3 wait cycles. The longer waits keep requests pending across several edges, which exposes any unstable address or data. They also leave room to offer a second command while the unit is still busy.

// File: rtl/pxu_pkg.sv
package pxu_pkg;

    localparam int STEP_W = 2;

    typedef enum logic [3:0] {
        OP_LDPI = 4'd0,   // pair <- operand
        OP_LDHD = 4'd1,   // HL <- mem[operand]
        OP_STHD = 4'd2,   // mem[operand] <- HL
        OP_XDH  = 4'd3,   // HL <-> DE
        OP_HSP  = 4'd4,   // SP <- HL
        OP_HPC  = 4'd5,   // PC <- HL
        OP_XTS  = 4'd6,   // HL <-> top of stack
        OP_PSH  = 4'd7,   // push pair
        OP_POP  = 4'd8,   // pop pair
        OP_RTN  = 4'd9,   // pop into PC
        OP_LDAI = 4'd10,  // A <- mem[BC/DE]
        OP_STAI = 4'd11   // mem[BC/DE] <- A
    } op_e;

    function automatic logic is_mem_op(input op_e op);
        return op inside {OP_LDHD, OP_STHD, OP_XTS, OP_PSH,
                          OP_POP, OP_RTN, OP_LDAI, OP_STAI};
    endfunction

    function automatic logic is_reg_op(input op_e op);
        return op inside {OP_LDPI, OP_XDH, OP_HSP, OP_HPC};
    endfunction

endpackage

// File: rtl/pxu_access.sv
// Maps the current command step to one byte access on the memory port.
module pxu_access
    import pxu_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int ADDR_W = 2 * DATA_W
) (
    input  op_e               op,
    input  logic [STEP_W-1:0] step,
    input  logic [1:0]        pair,
    input  logic [ADDR_W-1:0] imm,
    input  logic [ADDR_W-1:0] sp,
    input  logic [ADDR_W-1:0] bc,
    input  logic [ADDR_W-1:0] de,
    input  logic [ADDR_W-1:0] hl,
    input  logic [DATA_W-1:0] acc,
    output logic [ADDR_W-1:0] addr,
    output logic              we,
    output logic [DATA_W-1:0] wdata,
    output logic              last
);
    logic [ADDR_W-1:0] push_word;

    always_comb begin
        case (pair)
            2'd0:    push_word = bc;
            2'd1:    push_word = de;
            2'd2:    push_word = hl;
            default: push_word = {acc, DATA_W'(0)};
        endcase
    end

    always_comb begin
        addr  = sp;
        we    = 1'b0;
        wdata = '0;
        last  = 1'b1;
        case (op)
            OP_LDHD: begin
                addr = imm + ADDR_W'(step[0]);
                last = step[0];
            end
            OP_STHD: begin
                addr  = imm + ADDR_W'(step[0]);
                we    = 1'b1;
                wdata = step[0] ? hl[ADDR_W-1:DATA_W] : hl[DATA_W-1:0];
                last  = step[0];
            end
            OP_XTS: begin
                addr  = sp + ADDR_W'(step[1]);
                we    = step[0];
                wdata = step[1] ? hl[ADDR_W-1:DATA_W] : hl[DATA_W-1:0];
                last  = (step == STEP_W'(3));
            end
            OP_PSH: begin
                addr  = sp - ADDR_W'(1);
                we    = 1'b1;
                wdata = step[0] ? push_word[DATA_W-1:0] : push_word[ADDR_W-1:DATA_W];
                last  = step[0];
            end
            OP_POP, OP_RTN: begin
                addr = sp;
                last = step[0];
            end
            OP_LDAI: begin
                addr = pair[0] ? de : bc;
            end
            OP_STAI: begin
                addr  = pair[0] ? de : bc;
                we    = 1'b1;
                wdata = acc;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pxu_regs.sv
// Architectural registers: accumulator, BC, DE, HL, SP, PC.
module pxu_regs
    import pxu_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int ADDR_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  op_e               cmd_op,
    input  logic [1:0]        cmd_pair,
    input  logic [ADDR_W-1:0] cmd_imm,
    input  logic              done,
    input  op_e               op_q,
    input  logic [1:0]        pair_q,
    input  logic [STEP_W-1:0] step_q,
    input  logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] tmp,
    output logic [DATA_W-1:0] acc_o,
    output logic [ADDR_W-1:0] bc_o,
    output logic [ADDR_W-1:0] de_o,
    output logic [ADDR_W-1:0] hl_o,
    output logic [ADDR_W-1:0] sp_o,
    output logic [ADDR_W-1:0] pc_o
);
    typedef struct packed {
        logic [DATA_W-1:0] a, b, c, d, e, h, l;
        logic [ADDR_W-1:0] sp, pc;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (start) begin
            case (cmd_op)
                OP_LDPI: case (cmd_pair)
                    2'd0:    {r_d.b, r_d.c} = cmd_imm;
                    2'd1:    {r_d.d, r_d.e} = cmd_imm;
                    2'd2:    {r_d.h, r_d.l} = cmd_imm;
                    default: r_d.sp = cmd_imm;
                endcase
                OP_XDH: begin
                    {r_d.h, r_d.l} = {r_q.d, r_q.e};
                    {r_d.d, r_d.e} = {r_q.h, r_q.l};
                end
                OP_HSP:  r_d.sp = {r_q.h, r_q.l};
                OP_HPC:  r_d.pc = {r_q.h, r_q.l};
                default: ;
            endcase
        end
        if (done) begin
            case (op_q)
                OP_LDHD: begin
                    if (step_q[0]) r_d.h = rdata;
                    else           r_d.l = rdata;
                end
                OP_XTS: begin
                    if (step_q == STEP_W'(1)) r_d.l = tmp;
                    if (step_q == STEP_W'(3)) r_d.h = tmp;
                end
                OP_PSH: r_d.sp = r_q.sp - ADDR_W'(1);
                OP_POP: begin
                    r_d.sp = r_q.sp + ADDR_W'(1);
                    if (!step_q[0]) begin
                        case (pair_q)
                            2'd0:    r_d.c = rdata;
                            2'd1:    r_d.e = rdata;
                            2'd2:    r_d.l = rdata;
                            default: ;
                        endcase
                    end else begin
                        case (pair_q)
                            2'd0:    r_d.b = rdata;
                            2'd1:    r_d.d = rdata;
                            2'd2:    r_d.h = rdata;
                            default: r_d.a = rdata;
                        endcase
                    end
                end
                OP_RTN: begin
                    r_d.sp = r_q.sp + ADDR_W'(1);
                    if (step_q[0]) r_d.pc[ADDR_W-1:DATA_W] = rdata;
                    else           r_d.pc[DATA_W-1:0]      = rdata;
                end
                OP_LDAI: r_d.a = rdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign acc_o = r_q.a;
    assign bc_o  = {r_q.b, r_q.c};
    assign de_o  = {r_q.d, r_q.e};
    assign hl_o  = {r_q.h, r_q.l};
    assign sp_o  = r_q.sp;
    assign pc_o  = r_q.pc;

    assert_reset_clear_R13: assert property (@(posedge clk)
        rst |=> (acc_o == '0 && bc_o == '0 && de_o == '0 && hl_o == '0 &&
                 sp_o == '0 && pc_o == '0));

    assert_swap_de_hl_R4: assert property (@(posedge clk) disable iff (rst)
        (start && cmd_op == OP_XDH) |=> (hl_o == $past(de_o) && de_o == $past(hl_o)));

    assert_xts_keeps_sp_R6: assert property (@(posedge clk) disable iff (rst)
        (done && op_q == OP_XTS) |=> $stable(sp_o));

    assert_push_dec_sp_R7: assert property (@(posedge clk) disable iff (rst)
        (done && op_q == OP_PSH) |=> (sp_o == $past(sp_o) - ADDR_W'(1)));

    assert_pop_inc_sp_R8: assert property (@(posedge clk) disable iff (rst)
        (done && (op_q == OP_POP || op_q == OP_RTN)) |=> (sp_o == $past(sp_o) + ADDR_W'(1)));
endmodule

// File: rtl/pair_xfer_unit.sv
module pair_xfer_unit
    import pxu_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int ADDR_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [3:0]        cmd_op,
    input  logic [1:0]        cmd_pair,
    input  logic [ADDR_W-1:0] cmd_imm,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready,
    output logic [DATA_W-1:0] acc_o,
    output logic [ADDR_W-1:0] bc_o,
    output logic [ADDR_W-1:0] de_o,
    output logic [ADDR_W-1:0] hl_o,
    output logic [ADDR_W-1:0] sp_o,
    output logic [ADDR_W-1:0] pc_o
);
    typedef struct packed {
        logic              active;
        op_e               op;
        logic [1:0]        pair;
        logic [ADDR_W-1:0] imm;
        logic [STEP_W-1:0] step;
        logic [DATA_W-1:0] tmp;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    op_e  cmd_e;
    logic accept, done, start, acc_last;

    assign cmd_e  = op_e'(cmd_op);
    assign accept = cmd_valid && !ctl_q.active;
    assign done   = ctl_q.active && mem_ready;
    assign start  = accept && is_reg_op(cmd_e);

    pxu_access #(.DATA_W(DATA_W)) u_access (
        .op    (ctl_q.op),
        .step  (ctl_q.step),
        .pair  (ctl_q.pair),
        .imm   (ctl_q.imm),
        .sp    (sp_o),
        .bc    (bc_o),
        .de    (de_o),
        .hl    (hl_o),
        .acc   (acc_o),
        .addr  (mem_addr),
        .we    (mem_we),
        .wdata (mem_wdata),
        .last  (acc_last)
    );

    pxu_regs #(.DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .cmd_op   (cmd_e),
        .cmd_pair (cmd_pair),
        .cmd_imm  (cmd_imm),
        .done     (done),
        .op_q     (ctl_q.op),
        .pair_q   (ctl_q.pair),
        .step_q   (ctl_q.step),
        .rdata    (mem_rdata),
        .tmp      (ctl_q.tmp),
        .acc_o    (acc_o),
        .bc_o     (bc_o),
        .de_o     (de_o),
        .hl_o     (hl_o),
        .sp_o     (sp_o),
        .pc_o     (pc_o)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (accept && is_mem_op(cmd_e)) begin
            ctl_d.active = 1'b1;
            ctl_d.op     = cmd_e;
            ctl_d.pair   = cmd_pair;
            ctl_d.imm    = cmd_imm;
            ctl_d.step   = '0;
        end
        if (done) begin
            if (ctl_q.op == OP_XTS && !ctl_q.step[0]) ctl_d.tmp = mem_rdata;
            if (acc_last) ctl_d.active = 1'b0;
            else          ctl_d.step   = ctl_q.step + STEP_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= '0;
        else     ctl_q <= ctl_d;
    end

    assign busy    = ctl_q.active;
    assign mem_req = ctl_q.active;

    assert_req_held_R11: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) &&
                                     $stable(mem_we) && $stable(mem_wdata)));

    assert_busy_until_done_R10: assert property (@(posedge clk) disable iff (rst)
        (busy && !mem_ready) |=> busy);

    assert_reg_op_no_busy_R4: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !busy && is_reg_op(op_e'(cmd_op))) |=> !busy);

    assert_unknown_op_idle_R12: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !busy && cmd_op >= 4'd12) |=> !mem_req);
endmodule

// File: tb/tb_pair_xfer_unit.sv
module tb_pair_xfer_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [3:0]  cmd_op = '0;
    logic [1:0]  cmd_pair = '0;
    logic [15:0] cmd_imm = '0;
    logic        busy, mem_req, mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic        mem_ready = 1'b0;
    logic [7:0]  acc_o;
    logic [15:0] bc_o, de_o, hl_o, sp_o, pc_o;

    always #5 clk = ~clk;

    pair_xfer_unit dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_pair(cmd_pair), .cmd_imm(cmd_imm), .busy(busy), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready), .acc_o(acc_o),
        .bc_o(bc_o), .de_o(de_o), .hl_o(hl_o), .sp_o(sp_o), .pc_o(pc_o)
    );

    int n_chk  = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // scoreboard of expected memory accesses
    typedef struct {
        bit          we;
        logic [15:0] addr;
        logic [7:0]  data;
        string       tag;
    } xfer_t;
    xfer_t expq[$];

    task automatic expect_xfer(input bit we, input logic [15:0] addr, input logic [7:0] data, input string tag);
        xfer_t x;
        x.we = we; x.addr = addr; x.data = data; x.tag = tag;
        expq.push_back(x);
    endtask

    logic [7:0]  mem [256];
    int          wait_cycles = 0;
    int          wait_cnt = 0;
    logic [15:0] first_addr = '0;

    // memory responder and monitor
    always @(negedge clk) begin
        if (rst || !mem_req || mem_ready) begin
            mem_ready = 1'b0;
            wait_cnt  = 0;
        end else if (wait_cnt < wait_cycles) begin
            if (wait_cnt == 0) first_addr = mem_addr;
            wait_cnt++;
        end else begin
            if (wait_cycles > 0)
                chk(mem_addr == first_addr, "R11 address held while waiting", {16'h0, mem_addr}, {16'h0, first_addr});
            if (expq.size() == 0) begin
                chk(1'b0, "R11 unexpected access", {15'h0, mem_we, mem_addr}, 32'h0);
            end else begin
                xfer_t x;
                x = expq.pop_front();
                chk(x.we == mem_we && x.addr == mem_addr && (!x.we || x.data == mem_wdata), x.tag,
                    {7'h0, mem_we, mem_addr, mem_wdata}, {7'h0, x.we, x.addr, x.data});
            end
            if (mem_we) mem[mem_addr[7:0]] = mem_wdata;
            mem_rdata = mem[mem_addr[7:0]];
            mem_ready = 1'b1;
            wait_cnt  = 0;
        end
    end

    task automatic run(input logic [3:0] op, input logic [1:0] pr, input logic [15:0] imm, output bit busy_after);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_pair = pr; cmd_imm = imm;
        @(negedge clk);
        cmd_valid  = 1'b0;
        busy_after = busy;
        while (busy) @(negedge clk);
        chk(expq.size() == 0, "R10 every access completed before busy fell", expq.size(), 0);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        bit b;
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R13 reset state
        chk(bc_o == 0 && de_o == 0 && hl_o == 0, "R13 pairs clear", {bc_o, hl_o}, 0);
        chk(sp_o == 0 && pc_o == 0 && acc_o == 0 && !busy && !mem_req, "R13 sp/pc/acc/busy clear", {sp_o, pc_o}, 0);

        // R1 load pair immediate
        run(4'd0, 2'd0, 16'h1234, b);
        run(4'd0, 2'd1, 16'h5678, b);
        run(4'd0, 2'd2, 16'h9ABC, b);
        run(4'd0, 2'd3, 16'h0040, b);
        chk(bc_o == 16'h1234, "R1 BC", bc_o, 16'h1234);
        chk(de_o == 16'h5678, "R1 DE", de_o, 16'h5678);
        chk(hl_o == 16'h9ABC, "R1 HL", hl_o, 16'h9ABC);
        chk(sp_o == 16'h0040, "R1 SP", sp_o, 16'h0040);

        // R4 exchange HL with DE
        run(4'd3, 2'd0, 16'h0, b);
        chk(!b, "R4 busy stays low", b, 0);
        chk(hl_o == 16'h5678 && de_o == 16'h9ABC, "R4 swap", {hl_o, de_o}, 32'h56789ABC);
        run(4'd3, 2'd0, 16'h0, b);
        chk(hl_o == 16'h9ABC && de_o == 16'h5678, "R4 swap back", {hl_o, de_o}, 32'h9ABC5678);

        // R3 store HL direct, two wait cycles
        wait_cycles = 2;
        expect_xfer(1'b1, 16'h0020, 8'hBC, "R3 low byte write");
        expect_xfer(1'b1, 16'h0021, 8'h9A, "R3 high byte write");
        run(4'd2, 2'd0, 16'h0020, b);
        chk(b, "R10 busy during store", b, 1);

        // R2 load HL direct
        mem[8'h30] = 8'h11; mem[8'h31] = 8'h22;
        expect_xfer(1'b0, 16'h0030, 8'h0, "R2 low byte read");
        expect_xfer(1'b0, 16'h0031, 8'h0, "R2 high byte read");
        run(4'd1, 2'd0, 16'h0030, b);
        chk(hl_o == 16'h2211, "R2 HL loaded", hl_o, 16'h2211);

        // R7 push BC
        wait_cycles = 0;
        expect_xfer(1'b1, 16'h003F, 8'h12, "R7 push high first");
        expect_xfer(1'b1, 16'h003E, 8'h34, "R7 push low second");
        run(4'd7, 2'd0, 16'h0, b);
        chk(sp_o == 16'h003E, "R7 SP after push", sp_o, 16'h003E);

        // R8 pop into HL
        expect_xfer(1'b0, 16'h003E, 8'h0, "R8 pop low read");
        expect_xfer(1'b0, 16'h003F, 8'h0, "R8 pop high read");
        run(4'd8, 2'd2, 16'h0, b);
        chk(hl_o == 16'h1234 && sp_o == 16'h0040, "R8 pop HL", {hl_o, sp_o}, 32'h12340040);

        // R6 exchange HL with top of stack
        mem[8'h40] = 8'hA5; mem[8'h41] = 8'h5A;
        expect_xfer(1'b0, 16'h0040, 8'h0,  "R6 read SP");
        expect_xfer(1'b1, 16'h0040, 8'h34, "R6 write L");
        expect_xfer(1'b0, 16'h0041, 8'h0,  "R6 read SP+1");
        expect_xfer(1'b1, 16'h0041, 8'h12, "R6 write H");
        run(4'd6, 2'd0, 16'h0, b);
        chk(hl_o == 16'h5AA5 && sp_o == 16'h0040, "R6 HL swapped, SP kept", {hl_o, sp_o}, 32'h5AA50040);

        // R5 copies from HL
        run(4'd5, 2'd0, 16'h0, b);
        chk(pc_o == 16'h5AA5 && !b, "R5 PC from HL", pc_o, 16'h5AA5);
        run(4'd4, 2'd0, 16'h0, b);
        chk(sp_o == 16'h5AA5 && !b, "R5 SP from HL", sp_o, 16'h5AA5);
        run(4'd0, 2'd3, 16'h0040, b);

        // R8 return
        expect_xfer(1'b0, 16'h0040, 8'h0, "R8 return low read");
        expect_xfer(1'b0, 16'h0041, 8'h0, "R8 return high read");
        run(4'd9, 2'd0, 16'h0, b);
        chk(pc_o == 16'h1234 && sp_o == 16'h0042, "R8 return PC/SP", {pc_o, sp_o}, 32'h12340042);

        // R9 accumulator indirect
        mem[8'h78] = 8'hC3;
        expect_xfer(1'b0, 16'h5678, 8'h0, "R9 load via DE");
        run(4'd10, 2'd1, 16'h0, b);
        chk(acc_o == 8'hC3 && de_o == 16'h5678, "R9 A loaded, DE kept", {acc_o, de_o}, 32'hC35678);
        expect_xfer(1'b1, 16'h1234, 8'hC3, "R9 store via BC");
        run(4'd11, 2'd0, 16'h0, b);
        chk(bc_o == 16'h1234, "R9 BC kept", bc_o, 16'h1234);

        // R7 push accumulator word, then SP wrap
        expect_xfer(1'b1, 16'h0041, 8'hC3, "R7 push A high");
        expect_xfer(1'b1, 16'h0040, 8'h00, "R7 push zero low");
        run(4'd7, 2'd3, 16'h0, b);
        run(4'd0, 2'd3, 16'h0000, b);
        expect_xfer(1'b1, 16'hFFFF, 8'h56, "R7 wrap high");
        expect_xfer(1'b1, 16'hFFFE, 8'h78, "R7 wrap low");
        run(4'd7, 2'd1, 16'h0, b);
        chk(sp_o == 16'hFFFE, "R7 SP wrapped", sp_o, 16'hFFFE);

        // R10 command offered while busy is ignored
        wait_cycles = 3;
        expect_xfer(1'b0, 16'h0030, 8'h0, "R10 long read low");
        expect_xfer(1'b0, 16'h0031, 8'h0, "R10 long read high");
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 4'd1; cmd_pair = 2'd0; cmd_imm = 16'h0030;
        @(negedge clk);
        cmd_op = 4'd0; cmd_pair = 2'd0; cmd_imm = 16'hDEAD;
        chk(busy, "R10 busy after accept", busy, 1);
        @(negedge clk);
        cmd_valid = 1'b0;
        while (busy) @(negedge clk);
        chk(bc_o == 16'h1234 && hl_o == 16'h2211, "R10 offer ignored", {bc_o, hl_o}, 32'h12342211);

        // R12 unknown opcode
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 4'hE; cmd_pair = 2'd2; cmd_imm = 16'hFFFF;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(!busy && !mem_req, "R12 no activity", {busy, mem_req}, 0);
        chk(bc_o == 16'h1234 && de_o == 16'h5678 && hl_o == 16'h2211, "R12 pairs unchanged",
            {bc_o, hl_o}, 32'h12342211);
        chk(sp_o == 16'hFFFE && pc_o == 16'h1234 && acc_o == 8'hC3, "R12 sp/pc/acc unchanged",
            {sp_o, pc_o}, 32'hFFFE1234);

        // R13 reset again
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(bc_o == 0 && hl_o == 0 && sp_o == 0 && pc_o == 0 && acc_o == 0 && !busy,
            "R13 reset clears", {sp_o, pc_o}, 0);
        chk(expq.size() == 0, "R11 no leftover accesses", expq.size(), 0);
        finish_run();
    end
endmodule